// File: doc/BRIEF.md
# Polynomial Shift-Register Interval Timer

This block is an 8-bit interval timer for a small processor subsystem. It counts with a feedback shift register instead of a binary counter, and a fixed prescaler divides the input clock before each step. Software loads a start value, and the register then walks a fixed pseudo-random sequence, one step per prescaler period. When the sequence lands on the terminal code 0xFE, the block emits a one-clock timeout pulse. Because the terminal code is also the restart point of the sequence, the timer then keeps firing every 255 steps without being reloaded. The interval is chosen by picking a start value whose distance to 0xFE in the sequence is the wanted number of steps.

A control state machine has two states. In HALTED the register holds the stop code 0xFF and the prescaler is frozen. In RUNNING the prescaler counts and the register steps. The transitions are few. LOAD_RUN goes from either state to RUNNING on a load of any value other than 0xFF. LOAD_STOP goes from either state to HALTED on a load of 0xFF. RESET_STOP goes to HALTED on reset. While RUNNING, the transition TERM_HIT stays in RUNNING and raises the timeout when a step reaches 0xFE. The enable input only qualifies the pulse; counting goes on while it is low.

Top module: `lfsr_interval_timer`

## Requirements
- R1: After synchronous active-high reset, `timeout` is 0, the register holds 0xFF (HALTED), and no timeout occurs until a load.
- R2: Each step shifts the register left by one bit. The new bit 0 is the inverse of the XOR of old bits 7, 5, 4 and 3 (bit 0 is the LSB), so the number of steps from a start value to 0xFE follows from that rule.
- R3: The register steps once every PRESCALE clocks (default 31). The first step comes at the PRESCALE-th rising edge after the load edge.
- R4: Loading 0xFF enters HALTED. The register stays at 0xFF and no timeout is ever produced until another load.
- R5: When a step brings the register to 0xFE, `timeout` is high for exactly one clock, in the cycle after that step's edge. From a load of value v, it is first seen PRESCALE×n clocks after the load edge, where n is the step count of R2 (n = 255 for v = 0xFE).
- R6: After a timeout the sequence continues from 0xFE, so further timeouts follow every 255×PRESCALE clocks without a reload.
- R7: A load restarts both the prescaler and the register from the loaded value. A load takes priority over a step due on the same edge.
- R8: While `enable` is low, no timeout pulse is produced, but the prescaler and register keep counting, so the phase of later timeouts is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | One-clock strobe that loads `load_data` |
| load_data | input | 8 | Start value for the register |
| enable | input | 1 | Qualifies the timeout pulse |
| timeout | output | 1 | One-clock pulse when the sequence reaches 0xFE |

## Verification
The embedded assertions check the following on every cycle:
- the prescaler stays in range and is cleared by a load;
- a running register never holds the stop code;
- a halted register is stable;
- a timeout coincides with the terminal code, is a single cycle wide, and only follows an active enable.

The exact interval from every start value to its timeout, the period of repeated timeouts, the priority of a load over a coincident step, and the unchanged phase after the enable is reasserted can only be shown by the bench's timed scenarios. The bench measures these against step counts it derives from the feedback rule.

// File: rtl/lfsr_timer_pkg.sv
package lfsr_timer_pkg;
    localparam int REG_W = 8;
    localparam logic [REG_W-1:0] STOP_CODE = 8'hFF;
    localparam logic [REG_W-1:0] TERM_CODE = 8'hFE;

    typedef enum logic [0:0] {
        ST_HALTED  = 1'b0,
        ST_RUNNING = 1'b1
    } tmr_state_e;

    // Shift left; new LSB is the inverted parity of taps 7,5,4,3
    function automatic logic [REG_W-1:0] lfsr_advance(input logic [REG_W-1:0] cur);
        logic fb;
        fb = ~(cur[7] ^ cur[5] ^ cur[4] ^ cur[3]);
        return {cur[REG_W-2:0], fb};
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRESCALE = 31
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic tick
);
    localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] div_cnt;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            div_cnt <= '0;
        end else if (run) begin
            div_cnt <= (div_cnt == LAST) ? '0 : div_cnt + 1'b1;
        end
    end

    assign tick = run && (div_cnt == LAST);

    // R3
    presc_range_chk: assert property (@(posedge clk) disable iff (rst)
        div_cnt <= LAST);

    // R7
    presc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (div_cnt == '0));
endmodule

// File: rtl/tmr_shift_reg.sv
module tmr_shift_reg
    import lfsr_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [REG_W-1:0] load_data,
    input  logic             step,
    output logic [REG_W-1:0] q,
    output logic [REG_W-1:0] q_next
);
    assign q_next = lfsr_advance(q);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= STOP_CODE;
        end else if (load) begin
            q <= load_data;
        end else if (step) begin
            q <= q_next;
        end
    end

    // R7
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(load_data)));
endmodule

// File: rtl/tmr_ctrl_fsm.sv
module tmr_ctrl_fsm
    import lfsr_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       load_is_stop,
    input  logic       tick,
    input  logic       next_is_term,
    input  logic       enable,
    output tmr_state_e state,
    output logic       step,
    output logic       timeout
);
    tmr_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALTED:  if (load && !load_is_stop) state_nx = ST_RUNNING;
            ST_RUNNING: if (load && load_is_stop)  state_nx = ST_HALTED;
            default:    state_nx = ST_HALTED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_HALTED;
        else     state <= state_nx;
    end

    assign step = (state == ST_RUNNING) && tick && !load;

    always_ff @(posedge clk) begin
        if (rst) timeout <= 1'b0;
        else     timeout <= step && next_is_term && enable;
    end

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !timeout);

    // R8
    enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
        timeout |-> $past(enable));
endmodule

// File: rtl/lfsr_interval_timer.sv
module lfsr_interval_timer
    import lfsr_timer_pkg::*;
#(
    parameter int PRESCALE = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [REG_W-1:0] load_data,
    input  logic             enable,
    output logic             timeout
);
    tmr_state_e       state;
    logic             tick;
    logic             step;
    logic [REG_W-1:0] reg_q;
    logic [REG_W-1:0] reg_nx;

    tmr_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .run  (state == ST_RUNNING),
        .tick (tick)
    );

    tmr_shift_reg u_sreg (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_data (load_data),
        .step      (step),
        .q         (reg_q),
        .q_next    (reg_nx)
    );

    tmr_ctrl_fsm u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .load         (load),
        .load_is_stop (load_data == STOP_CODE),
        .tick         (tick),
        .next_is_term (reg_nx == TERM_CODE),
        .enable       (enable),
        .state        (state),
        .step         (step),
        .timeout      (timeout)
    );

    // R4
    run_not_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUNNING) |-> (reg_q != STOP_CODE));

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALTED && !load) |=> (reg_q == $past(reg_q)));

    // R6
    term_code_chk: assert property (@(posedge clk) disable iff (rst)
        timeout |-> (reg_q == TERM_CODE));
endmodule

// File: tb/test_lfsr_interval_timer.sv
module test_lfsr_interval_timer;
    localparam int PB = 31;
    localparam int PS = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_b = 1'b0;
    logic       ld_s = 1'b0;
    logic [7:0] din = 8'h00;
    logic       en = 1'b1;
    logic       tout_b;
    logic       tout_s;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lfsr_interval_timer #(.PRESCALE(PB)) i_lfsr_interval_timer (
        .clk(clk), .rst(rst), .load(ld_b), .load_data(din),
        .enable(en), .timeout(tout_b));

    lfsr_interval_timer #(.PRESCALE(PS)) i_small (
        .clk(clk), .rst(rst), .load(ld_s), .load_data(din),
        .enable(en), .timeout(tout_s));

    function automatic logic [7:0] model_next(input logic [7:0] v);
        return {v[6:0], ~(v[7] ^ v[5] ^ v[4] ^ v[3])};
    endfunction

    function automatic int steps_to_term(input logic [7:0] v);
        logic [7:0] x = v;
        int n = 0;
        do begin
            x = model_next(x);
            n++;
        end while (x != 8'hFE && n < 300);
        return n;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_load(input bit sm, input logic [7:0] v);
        @(negedge clk);
        din = v;
        if (sm) ld_s = 1'b1; else ld_b = 1'b1;
        @(negedge clk);
        ld_s = 1'b0;
        ld_b = 1'b0;
    endtask

    // Returns clocks until the pulse is seen, or -1 if none within limit
    task automatic wait_tout(input bit sm, input int limit, output int c);
        bit hit = 1'b0;
        c = 0;
        while (!hit && c < limit) begin
            @(negedge clk);
            c++;
            hit = sm ? tout_s : tout_b;
        end
        if (!hit) c = -1;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<190000", cycles);
                finish_up();
            end
        end
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 timeout after reset", int'(tout_b), 0);
        wait_tout(1'b0, 300, c);
        check("R1 no pulse while halted after reset", c, -1);

        // R3 R5: full cycle from 0xFE on the default prescaler
        do_load(1'b0, 8'hFE);
        wait_tout(1'b0, 9000, c);
        check("R3 R5 first timeout from FE", c, PB * 255);
        @(negedge clk);
        check("R5 pulse one clock wide", int'(tout_b), 0);
        // R6: periodic without reload
        wait_tout(1'b0, 9000, c);
        check("R6 period from FE", c + 1, PB * 255);

        // R7: reload coincides with a due step
        do_load(1'b0, 8'h01);
        repeat (29) @(negedge clk);
        do_load(1'b0, 8'h5A);
        wait_tout(1'b0, 9000, c);
        check("R7 reload restarts count", c, PB * steps_to_term(8'h5A));

        // R2 R5: sweep every running start value on the small prescaler
        for (int v = 0; v < 255; v++) begin
            do_load(1'b1, 8'(v));
            wait_tout(1'b1, PS * 256 + 4, c);
            check($sformatf("R2 sweep start=%02h", v), c, PS * steps_to_term(8'(v)));
        end

        // R4: load of 0xFF halts
        do_load(1'b1, 8'hFE);
        repeat (100) @(negedge clk);
        do_load(1'b1, 8'hFF);
        wait_tout(1'b1, PS * 600, c);
        check("R4 stop code never times out", c, -1);

        // R8: enable low suppresses pulses, counting continues
        en = 1'b0;
        do_load(1'b1, 8'hFE);
        wait_tout(1'b1, 530, c);
        check("R8 no pulse while disabled", c, -1);
        en = 1'b1;
        wait_tout(1'b1, 600, c);
        check("R8 phase kept after enable", c, 2 * PS * 255 - 530);

        finish_up();
    end
endmodule